// File: doc/BRIEF.md
# Linear Frequency Ramp Controller

This block moves a frequency control word from where it stands to a new target in a straight line, at a rate picked from a fixed table. It is used in two situations: leaving holdover, and switching between inputs when ramping is enabled. Both situations use the same rate setting. The ramp rate has no connection to the loop bandwidth, and the block neither reads nor changes the bandwidth.

A start pulse captures three things: the starting word, the target word and the rate code. From the starting word and the target, the block computes and stores the magnitude and direction of the distance to travel. At every internal tick it then moves the output one step toward the target. When the remaining distance is no larger than one step, the output lands exactly on the target, busy drops and done pulses for one cycle. When ramping is disabled, a bandwidth-governed exit is in charge: the block gives up control, so its output follows the externally supplied current word and it never ramps.

Top module: `freq_ramp`

## Requirements
- R1: After reset, `freq_o` is 0 and both `busy_o` and `done_o` are 0.
- R2: A `start_i` pulse with `ramp_en_i` high captures the target and the rate. The starting word is `cur_freq_i` when the block is idle. In the cycle after the pulse, `freq_o` shows the starting word, and `busy_o` is 1 when the start and the target differ.
- R3: While busy, `freq_o` moves by exactly one step every TICK_DIV clock cycles (default 4). The first move comes TICK_DIV cycles after the start is registered. The direction is up when the target is above the start and down otherwise.
- R4: Rate code c (6 bits) selects the step size in word LSBs: (2 + c[0]) shifted left by c[5:1], for c = 0 to 39. Codes 40 to 63 behave as code 39. The table spans 2 to 1,572,864 LSBs per tick.
- R5: The last step clamps to the target. During a ramp, `freq_o` never passes beyond the target.
- R6: On arrival, `busy_o` falls and `done_o` is high for exactly one cycle. Afterwards `freq_o` holds the target until the next start or until the block is disabled.
- R7: A start whose starting word equals its target produces a single-cycle `done_o` on the next cycle, and `busy_o` stays low.
- R8: A start during a ramp recaptures the distance from the present `freq_o` value and ignores `cur_freq_i`. It also restarts the tick spacing.
- R9: While `ramp_en_i` is low, starts are ignored and any ramp in progress is abandoned. `busy_o` and `done_o` are 0, and `freq_o` equals the `cur_freq_i` of the previous cycle.
- R10: The rate code is latched at start. Changes on `rate_sel_i` and `tgt_freq_i` during a ramp have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ramp_en_i | input | 1 | Ramped mode enable; low hands the output back to the bandwidth-governed path |
| start_i | input | 1 | Single-cycle request to begin a ramp |
| rate_sel_i | input | 6 | Rate table index |
| cur_freq_i | input | FW (32) | Present frequency word, used as the start point when idle |
| tgt_freq_i | input | FW (32) | Desired frequency word |
| freq_o | output | FW (32) | Ramped frequency word |
| busy_o | output | 1 | Ramp in progress |
| done_o | output | 1 | One-cycle arrival pulse |

## Verification
The assertions assume three things about the inputs: `start_i` is a clean single-cycle request, the rate is stable between starts, and frequency words never come within one step of wrapping around the word width. The stimulus holds the target distance to a few dozen steps of the selected rate. It keeps start and target words far enough from zero and from full scale that no step can wrap. Starts are issued as one-cycle pulses: random ones, plus directed restarts, disables and mid-ramp rate changes.

// File: rtl/freq_ramp_pkg.sv
package freq_ramp_pkg;
    localparam int RATE_W    = 6;
    localparam int NUM_RATES = 40;
    localparam int STEP_W    = 21;
    localparam int TBL_N     = 1 << RATE_W;

    // step size in word LSBs for one rate code
    function automatic logic [STEP_W-1:0] rate_step(input logic [RATE_W-1:0] code);
        logic [RATE_W-1:0] c;
        logic [STEP_W-1:0] mant;
        c    = (int'(code) >= NUM_RATES) ? RATE_W'(NUM_RATES - 1) : code;
        mant = c[0] ? STEP_W'(3) : STEP_W'(2);
        return mant << c[RATE_W-1:1];
    endfunction
endpackage

// File: rtl/freq_ramp_rate_rom.sv
module freq_ramp_rate_rom
    import freq_ramp_pkg::*;
(
    input  logic [RATE_W-1:0] code_i,
    output logic [STEP_W-1:0] step_o
);
    logic [STEP_W-1:0] table_w [TBL_N];

    for (genvar g = 0; g < TBL_N; g++) begin : g_entry
        assign table_w[g] = rate_step(RATE_W'(g));
    end

    assign step_o = table_w[code_i];

    always_comb begin
        assert (step_o != '0) else $error("AST_STEP_NONZERO"); // R4
    end
endmodule

// File: rtl/freq_ramp_tick.sv
module freq_ramp_tick #(
    parameter int TICK_DIV = 4,
    localparam int CW = (TICK_DIV < 2) ? 1 : $clog2(TICK_DIV)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic tick_o
);
    logic [CW-1:0] cnt_d, cnt_q;
    logic          at_end;

    assign at_end = (cnt_q == CW'(TICK_DIV - 1));
    assign tick_o = run_i && at_end && !clear_i;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i || !run_i) cnt_d = '0;
        else if (at_end)       cnt_d = '0;
        else                   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R3
endmodule

// File: rtl/freq_ramp_step.sv
module freq_ramp_step #(
    parameter int FW = 32,
    parameter int SW = 21
) (
    input  logic [FW-1:0] freq_i,
    input  logic [FW-1:0] tgt_i,
    input  logic [FW-1:0] rem_i,
    input  logic [SW-1:0] step_i,
    input  logic          down_i,
    output logic [FW-1:0] freq_o,
    output logic [FW-1:0] rem_o,
    output logic          last_o
);
    logic [FW-1:0] step_ext;

    assign step_ext = FW'(step_i);

    always_comb begin
        last_o = (rem_i <= step_ext);
        if (last_o) begin
            freq_o = tgt_i;
            rem_o  = '0;
        end else begin
            freq_o = down_i ? (freq_i - step_ext) : (freq_i + step_ext);
            rem_o  = rem_i - step_ext;
        end
    end
endmodule

// File: rtl/freq_ramp.sv
module freq_ramp
    import freq_ramp_pkg::*;
#(
    parameter int FW       = 32,
    parameter int TICK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ramp_en_i,
    input  logic              start_i,
    input  logic [RATE_W-1:0] rate_sel_i,
    input  logic [FW-1:0]     cur_freq_i,
    input  logic [FW-1:0]     tgt_freq_i,
    output logic [FW-1:0]     freq_o,
    output logic              busy_o,
    output logic              done_o
);
    typedef struct packed {
        logic [FW-1:0]     freq;
        logic [FW-1:0]     tgt;
        logic [FW-1:0]     rem;
        logic [STEP_W-1:0] step;
        logic              down;
        logic              busy;
        logic              done;
    } ramp_st_t;

    ramp_st_t st_d, st_q;

    logic [STEP_W-1:0] rom_step;
    logic              tick;
    logic              go;
    logic [FW-1:0]     nx_freq, nx_rem;
    logic              nx_last;
    logic [FW-1:0]     base;

    assign go = ramp_en_i && start_i;

    freq_ramp_rate_rom u_rom (
        .code_i (rate_sel_i),
        .step_o (rom_step)
    );

    freq_ramp_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (go || !ramp_en_i),
        .run_i   (st_q.busy),
        .tick_o  (tick)
    );

    freq_ramp_step #(.FW(FW), .SW(STEP_W)) u_step (
        .freq_i (st_q.freq),
        .tgt_i  (st_q.tgt),
        .rem_i  (st_q.rem),
        .step_i (st_q.step),
        .down_i (st_q.down),
        .freq_o (nx_freq),
        .rem_o  (nx_rem),
        .last_o (nx_last)
    );

    assign base = st_q.busy ? st_q.freq : cur_freq_i;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!ramp_en_i) begin
            st_d.freq = cur_freq_i;
            st_d.busy = 1'b0;
            st_d.rem  = '0;
        end else if (start_i) begin
            st_d.freq = base;
            st_d.tgt  = tgt_freq_i;
            st_d.step = rom_step;
            st_d.down = (tgt_freq_i < base);
            st_d.rem  = (tgt_freq_i < base) ? (base - tgt_freq_i) : (tgt_freq_i - base);
            st_d.busy = (tgt_freq_i != base);
            st_d.done = (tgt_freq_i == base);
        end else if (st_q.busy && tick) begin
            st_d.freq = nx_freq;
            st_d.rem  = nx_rem;
            if (nx_last) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign freq_o = st_q.freq;
    assign busy_o = st_q.busy;
    assign done_o = st_q.done;

    AST_DONE_ON_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (freq_o == st_q.tgt)); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !go) |=> !done_o); // R6
    AST_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (st_q.down ? (freq_o > st_q.tgt) : (freq_o < st_q.tgt))); // R5
    AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && ramp_en_i && !start_i) |=>
            ((freq_o == $past(freq_o)) || (freq_o == st_q.tgt) ||
             (freq_o == $past(freq_o) + FW'(st_q.step)) ||
             (freq_o == $past(freq_o) - FW'(st_q.step)))); // R3
    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ramp_en_i |=> (!busy_o && !done_o)); // R9
    AST_RATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !start_i) |=> $stable(st_q.step)); // R10
endmodule

// File: tb/sim_freq_ramp.sv
module sim_freq_ramp;
    localparam int FW  = 32;
    localparam int DIV = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          start = 1'b0;
    logic [5:0]    rate = '0;
    logic [FW-1:0] cur = '0;
    logic [FW-1:0] tgt = '0;
    logic [FW-1:0] freq_o;
    logic          busy_o, done_o;

    int total = 0;
    int bad = 0;
    string tag = "R1";
    bit cmp_on = 1'b0;

    always #10 clk = ~clk;

    freq_ramp #(.FW(FW), .TICK_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .ramp_en_i(en), .start_i(start),
        .rate_sel_i(rate), .cur_freq_i(cur), .tgt_freq_i(tgt),
        .freq_o(freq_o), .busy_o(busy_o), .done_o(done_o)
    );

    function automatic logic [FW-1:0] step_of(input logic [5:0] c);
        int k;
        k = (int'(c) > 39) ? 39 : int'(c);
        return FW'((2 + (k % 2))) << (k / 2);
    endfunction

    // reference model, updated from requirement text
    logic [FW-1:0] m_freq, m_tgt, m_rem, m_step;
    logic          m_dn, m_busy, m_done;
    int            m_cnt;

    always @(posedge clk) begin
        logic [FW-1:0] b;
        if (!rst_n) begin
            m_freq = '0; m_busy = 0; m_done = 0; m_cnt = 0;
            m_tgt = '0; m_rem = '0; m_step = '0; m_dn = 0;
        end else if (!en) begin
            m_freq = cur; m_busy = 0; m_done = 0; m_cnt = 0;
        end else if (start) begin
            b = m_busy ? m_freq : cur;
            m_freq = b; m_tgt = tgt; m_step = step_of(rate);
            m_dn = tgt < b; m_rem = m_dn ? b - tgt : tgt - b;
            m_busy = (b != tgt); m_done = (b == tgt); m_cnt = 0;
        end else if (m_busy) begin
            m_done = 0;
            if (m_cnt == DIV - 1) begin
                m_cnt = 0;
                if (m_rem <= m_step) begin
                    m_freq = m_tgt; m_rem = '0; m_busy = 0; m_done = 1;
                end else begin
                    m_freq = m_dn ? m_freq - m_step : m_freq + m_step;
                    m_rem = m_rem - m_step;
                end
            end else m_cnt++;
        end else begin
            m_done = 0; m_cnt = 0;
        end
    end

    task automatic check(input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            check({tag, " freq"}, freq_o, m_freq);
            check({tag, " busy"}, FW'(busy_o), FW'(m_busy));
            check({tag, " done"}, FW'(done_o), FW'(m_done));
        end
    end

    task automatic pulse_start(input logic [FW-1:0] c, input logic [FW-1:0] t, input logic [5:0] r);
        @(negedge clk);
        cur = c; tgt = t; rate = r; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400 && busy_o; i++) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 freq", freq_o, '0);
        check("R1 busy", FW'(busy_o), '0);
        check("R1 done", FW'(done_o), '0);
        rst_n = 1'b1;
        en = 1'b1;
        cmp_on = 1'b1;

        // R2 R3 R5 up ramp, smallest step, clamp at end
        tag = "R3";
        pulse_start(100, 111, 0);
        check("R2 start word", freq_o, 100);
        check("R2 busy", FW'(busy_o), 1);
        repeat (DIV) @(negedge clk);
        check("R3 first step", freq_o, 102);
        tag = "R5";
        wait_idle();
        check("R5 clamp", freq_o, 111);

        // R3 down ramp with code 5 (12 LSBs)
        tag = "R3";
        pulse_start(1000, 950, 5);
        repeat (DIV) @(negedge clk);
        check("R3 down step", freq_o, 988);
        wait_idle();
        tag = "R6";
        repeat (5) @(negedge clk);
        check("R6 hold target", freq_o, 950);

        // R7 equal start
        tag = "R7";
        pulse_start(500, 500, 3);
        check("R7 done", FW'(done_o), 1);
        check("R7 busy", FW'(busy_o), 0);
        @(negedge clk);

        // R8 restart mid ramp from present output
        tag = "R8";
        pulse_start(2000, 2400, 4);
        repeat (DIV * 2 + 1) @(negedge clk);
        pulse_start(99999, 1900, 4);
        check("R8 recapture", freq_o, 2016);
        wait_idle();

        // R10 rate and target change mid ramp ignored
        tag = "R10";
        pulse_start(3000, 3100, 2);
        rate = 39; tgt = 5;
        repeat (DIV) @(negedge clk);
        check("R10 step held", freq_o, 3004);
        wait_idle();
        check("R10 target held", freq_o, 3100);

        // R9 disable aborts and blocks start
        tag = "R9";
        pulse_start(4000, 4800, 1);
        repeat (DIV + 2) @(negedge clk);
        en = 1'b0; cur = 7777; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R9 busy", FW'(busy_o), 0);
        check("R9 follow", freq_o, 7777);
        en = 1'b1;
        @(negedge clk);

        // R4 out-of-range code equals code 39
        tag = "R4";
        pulse_start(10, 10 + 1572864 * 2 + 5, 63);
        repeat (DIV) @(negedge clk);
        check("R4 code63 step", freq_o, 10 + 1572864);
        wait_idle();

        // constrained random
        tag = "R3 rand";
        void'($urandom(32'h5eed_0042));
        for (int n = 0; n < 60; n++) begin
            logic [5:0]    r;
            logic [FW-1:0] s, d, c0;
            r  = 6'($urandom % 64);
            s  = step_of(r);
            d  = s * FW'($urandom % 12) + FW'($urandom % 64'(s));
            c0 = 32'h4000_0000 + FW'($urandom % 32'h100_0000);
            pulse_start(c0, ($urandom % 2) ? c0 + d : c0 - d, r);
            if ($urandom % 5 == 0) begin
                repeat ($urandom % 10) @(negedge clk);
                pulse_start(c0, c0 + 37, r);
            end
            wait_idle();
        end
        cmp_on = 1'b0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule